// File: doc/BRIEF.md
# Low-Power Mode Recovery Controller

This block sequences a microcontroller core through its two low-power modes and back out of them. The CPU asks for a light sleep (wait) or a deep sleep (stop). In the light sleep only the CPU clock is gated, so peripherals and their interrupt sources keep running. In the deep sleep the CPU clock, the peripheral clocks and the oscillator output are all gated. A single shared counter stays cleared for the whole deep sleep. When a wake arrives, the counter times the oscillator settling period before the CPU is allowed to resume and stack for the interrupt. The settling period is long (4096 clocks) or short (32 clocks), selected by a configuration bit.

A reset from the pin or from an internal source can arrive in any mode. It starts a reset recovery made of two 32-clock phases, after which the reset vector fetch is released. A sticky status flag records a break interrupt that arrived during either low-power mode. Software clears the flag by a write, and any reset clears it as well.

Top module: `lpm_recovery`

## Requirements
- R1: After the synchronous reset `rst`, the block is running: `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1, while `resume_ready`, `rst_vec_go` and `brk_flag` are all 0.
- R2: A `wait_req` pulse while running gives, from the next cycle on, `cpu_clk_en`=0 with `per_clk_en`=1 and `osc_en`=1.
- R3: A `stop_req` pulse while running gives, from the next cycle on, all three enables at 0. The recovery counter is held cleared for as long as the block stays in stop.
- R4: In wait, a cycle with `irq` or `brk` high restores all three enables in the next cycle. No `resume_ready` pulse is produced.
- R5: In stop, a cycle with `irq` or `brk` high starts a recovery. During the recovery only `osc_en` is 1. `resume_ready` is high for exactly one cycle, which is the Nth cycle of the recovery. N is 32 if `short_rec` was 1 in the cycle `stop_req` was taken, and 4096 if it was 0. All enables return in the cycle after that pulse.
- R6: If `stop_req` or `wait_req` arrives in the same cycle as `irq` or `brk`, the wake wins and the block stays running.
- R7: If `stop_req` and `wait_req` are high together, stop is entered.
- R8: A high on `rst_pin` or `int_rst` in any state outside reset recovery starts a reset recovery. In that recovery `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` are 1. `rst_vec_go` is high for one cycle, the 64th cycle of the recovery (two phases of 32 cycles each), and the block runs from the next cycle.
- R9: `brk_flag` is set by `brk` in wait or stop, is not set by `brk` while running, and stays set until it is cleared.
- R10: `brk_flag` is cleared in the cycle after `brk_flag_clr` is high, or after `rst_pin` or `int_rst` is high. A `brk` that sets the flag wins over a software clear in the same cycle.
- R11: `irq` and `brk` during a stop recovery neither shorten the recovery nor cause an extra `resume_ready` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_req | input | 1 | CPU request to enter wait |
| stop_req | input | 1 | CPU request to enter stop |
| rst_pin | input | 1 | External reset pin, active high |
| int_rst | input | 1 | Internal reset request |
| irq | input | 1 | CPU interrupt request |
| brk | input | 1 | Break interrupt |
| short_rec | input | 1 | 1 selects the 32-cycle stop recovery |
| brk_flag_clr | input | 1 | Software write that clears the break flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator output enable |
| resume_ready | output | 1 | One-cycle pulse: stacking may begin |
| rst_vec_go | output | 1 | One-cycle pulse: reset vector fetch may begin |
| brk_flag | output | 1 | Sticky break-in-low-power flag |

## Verification
A request, a wake or a flag write changes the enables and the flag one clock after the edge that samples it. The bench therefore drives each stimulus right after a falling edge and reads the outputs at the next falling edge. For recoveries, the falling edges are counted from the edge that took the wake. `resume_ready` is due at sample 32 or 4096, and `rst_vec_go` at sample 64. The clocks return one sample after the pulse, so each check compares the exact sample index against the value computed by the bench.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_STOP  = 3'd2,
        ST_RECOV = 3'd3,
        ST_RPH1  = 3'd4,
        ST_RPH2  = 3'd5
    } lpm_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } clk_gate_t;

    typedef struct packed {
        logic ext_rst;
        logic int_rst;
        logic irq;
        logic brk;
    } wake_t;

    function automatic clk_gate_t gates_for(lpm_state_e s);
        clk_gate_t g;
        case (s)
            ST_RUN:   g = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
            ST_WAIT:  g = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
            ST_STOP:  g = '{cpu: 1'b0, per: 1'b0, osc: 1'b0};
            ST_RECOV: g = '{cpu: 1'b0, per: 1'b0, osc: 1'b1};
            default:  g = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
        endcase
        return g;
    endfunction

    function automatic logic is_timed(lpm_state_e s);
        return (s == ST_RECOV) || (s == ST_RPH1) || (s == ST_RPH2);
    endfunction

    function automatic logic any_reset(wake_t w);
        return w.ext_rst | w.int_rst;
    endfunction

    function automatic logic any_int(wake_t w);
        return w.irq | w.brk;
    endfunction

endpackage

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int LONG_REC  = 4096,
    parameter int SHORT_REC = 32,
    parameter int RST_PHASE = 32,
    localparam int CW = $clog2(LONG_REC)
) (
    input  logic          clk,
    input  logic          rst,
    input  wake_t         wk,
    input  logic          stop_req,
    input  logic          wait_req,
    input  logic          short_rec,
    input  logic          term,
    output lpm_state_e    state,
    output logic          restart,
    output logic [CW-1:0] tgt
);

    lpm_state_e st_q, st_d;
    logic       short_q;

    always_comb begin
        st_d = st_q;
        if (st_q != ST_RPH1 && st_q != ST_RPH2 && any_reset(wk)) begin
            st_d = ST_RPH1;
        end else begin
            case (st_q)
                ST_RUN: begin
                    if (!any_int(wk)) begin
                        if (stop_req)      st_d = ST_STOP;
                        else if (wait_req) st_d = ST_WAIT;
                    end
                end
                ST_WAIT:  if (any_int(wk)) st_d = ST_RUN;
                ST_STOP:  if (any_int(wk)) st_d = ST_RECOV;
                ST_RECOV: if (term)        st_d = ST_RUN;
                ST_RPH1:  if (term)        st_d = ST_RPH2;
                ST_RPH2:  if (term)        st_d = ST_RUN;
                default:                   st_d = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_RUN;
            short_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_RUN && st_d == ST_STOP) short_q <= short_rec;
        end
    end

    always_comb begin
        if (st_q == ST_RECOV)
            tgt = short_q ? CW'(SHORT_REC - 1) : CW'(LONG_REC - 1);
        else
            tgt = CW'(RST_PHASE - 1);
    end

    assign state   = st_q;
    assign restart = (st_d != st_q);

endmodule

// File: rtl/lpm_timer.sv
module lpm_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          timed,
    input  logic          restart,
    input  logic [CW-1:0] tgt,
    output logic          term
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !timed) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    assign term = timed && (cnt_q == tgt);

endmodule

// File: rtl/lpm_brkflag.sv
module lpm_brkflag (
    input  logic clk,
    input  logic rst,
    input  logic hw_clr,
    input  logic set,
    input  logic sw_clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst || hw_clr) flag <= 1'b0;
        else if (set)      flag <= 1'b1;
        else if (sw_clr)   flag <= 1'b0;
    end

endmodule

// File: rtl/lpm_recovery.sv
module lpm_recovery
    import lpm_pkg::*;
#(
    parameter int LONG_REC  = 4096,
    parameter int SHORT_REC = 32,
    parameter int RST_PHASE = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic wait_req,
    input  logic stop_req,
    input  logic rst_pin,
    input  logic int_rst,
    input  logic irq,
    input  logic brk,
    input  logic short_rec,
    input  logic brk_flag_clr,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_en,
    output logic resume_ready,
    output logic rst_vec_go,
    output logic brk_flag
);

    localparam int CW = $clog2(LONG_REC);

    wake_t         wk;
    lpm_state_e    state;
    logic          restart;
    logic          term;
    logic [CW-1:0] tgt;
    clk_gate_t     gates;
    logic          low_pwr;

    assign wk = '{ext_rst: rst_pin, int_rst: int_rst, irq: irq, brk: brk};

    lpm_seq #(
        .LONG_REC (LONG_REC),
        .SHORT_REC(SHORT_REC),
        .RST_PHASE(RST_PHASE)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wk       (wk),
        .stop_req (stop_req),
        .wait_req (wait_req),
        .short_rec(short_rec),
        .term     (term),
        .state    (state),
        .restart  (restart),
        .tgt      (tgt)
    );

    lpm_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .timed  (is_timed(state)),
        .restart(restart),
        .tgt    (tgt),
        .term   (term)
    );

    assign low_pwr = (state == ST_WAIT) || (state == ST_STOP);

    lpm_brkflag u_flag (
        .clk   (clk),
        .rst   (rst),
        .hw_clr(any_reset(wk)),
        .set   (brk && low_pwr),
        .sw_clr(brk_flag_clr),
        .flag  (brk_flag)
    );

    assign gates        = gates_for(state);
    assign cpu_clk_en   = gates.cpu;
    assign per_clk_en   = gates.per;
    assign osc_en       = gates.osc;
    assign resume_ready = (state == ST_RECOV) && term;
    assign rst_vec_go   = (state == ST_RPH2) && term;

endmodule

// File: rtl/lpm_recovery_chk.sv
module lpm_recovery_chk (
    input logic clk,
    input logic rst,
    input logic stop_req,
    input logic wait_req,
    input logic rst_pin,
    input logic int_rst,
    input logic irq,
    input logic brk,
    input logic brk_flag_clr,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic osc_en,
    input logic resume_ready,
    input logic rst_vec_go,
    input logic brk_flag
);

    // R3
    osc_off_gates_all_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (!cpu_clk_en && !per_clk_en));

    // R5
    resume_clocks_back_chk: assert property (@(posedge clk) disable iff (rst)
        resume_ready && !rst_pin && !int_rst |=> (cpu_clk_en && per_clk_en && osc_en));

    // R5
    resume_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resume_ready |=> !resume_ready);

    // R8
    vector_then_run_chk: assert property (@(posedge clk) disable iff (rst)
        rst_vec_go |=> cpu_clk_en);

    // R6
    wake_beats_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && (stop_req || wait_req) && (irq || brk) && !rst_pin && !int_rst)
        |=> cpu_clk_en);

    // R9
    flag_needs_break_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_flag) |-> $past(brk));

    // R10
    flag_sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_flag_clr && !brk) |=> !brk_flag);

endmodule

bind lpm_recovery lpm_recovery_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_req    (stop_req),
    .wait_req    (wait_req),
    .rst_pin     (rst_pin),
    .int_rst     (int_rst),
    .irq         (irq),
    .brk         (brk),
    .brk_flag_clr(brk_flag_clr),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_en      (osc_en),
    .resume_ready(resume_ready),
    .rst_vec_go  (rst_vec_go),
    .brk_flag    (brk_flag)
);

// File: tb/sim_lpm_recovery.sv
module sim_lpm_recovery;

    logic clk = 1'b0;
    logic rst, wait_req, stop_req, rst_pin, int_rst, irq, brk, short_rec, brk_flag_clr;
    logic cpu_clk_en, per_clk_en, osc_en, resume_ready, rst_vec_go, brk_flag;

    int vecs = 0;
    int errs = 0;
    logic expf = 1'b0;

    always #2 clk = ~clk;

    lpm_recovery u0 (
        .clk(clk), .rst(rst), .wait_req(wait_req), .stop_req(stop_req),
        .rst_pin(rst_pin), .int_rst(int_rst), .irq(irq), .brk(brk),
        .short_rec(short_rec), .brk_flag_clr(brk_flag_clr),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .resume_ready(resume_ready), .rst_vec_go(rst_vec_go), .brk_flag(brk_flag)
    );

    function automatic int exp_delay(input logic s);
        return s ? 32 : 4096;
    endfunction

    function automatic logic [2:0] gates_of(input logic run, input logic cpu_only_off);
        return run ? 3'b111 : (cpu_only_off ? 3'b011 : 3'b000);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    function automatic int gv();
        return {cpu_clk_en, per_clk_en, osc_en};
    endfunction

    task automatic idle();
        wait_req = 0; stop_req = 0; rst_pin = 0; int_rst = 0;
        irq = 0; brk = 0; brk_flag_clr = 0;
    endtask

    task automatic go_wait();
        wait_req = 1; tick(); wait_req = 0;
        chk("R2 wait gates", gv(), gates_of(0, 1));
    endtask

    task automatic wake_wait(input logic use_brk);
        if (use_brk) brk = 1; else irq = 1;
        tick(); idle();
        if (use_brk) expf = 1;
        chk("R4 wait wake gates", gv(), 3'b111);
        chk("R4 no resume pulse", resume_ready, 0);
        chk("R9 flag after wait wake", brk_flag, expf);
    endtask

    task automatic go_stop(input logic s);
        short_rec = s; stop_req = 1; tick(); stop_req = 0;
        short_rec = ~s;
        chk("R3 stop gates", gv(), 3'b000);
    endtask

    task automatic stop_recover(input logic s, input logic use_brk);
        int n;
        int bad;
        if (use_brk) brk = 1; else irq = 1;
        tick(); idle();
        if (use_brk) expf = 1;
        n = 1; bad = 0;
        chk("R5 recovery gates", gv(), 3'b001);
        while (!resume_ready && n < 5000) begin
            if (n == 10) irq = 1;
            if (n == 12) brk = 1;
            tick(); idle(); n++;
            if (gv() != 3'b001) bad++;
        end
        chk("R5/R11 resume cycle", n, exp_delay(s));
        chk("R5 gates held in recovery", bad, 0);
        tick();
        chk("R5 gates after resume", gv(), 3'b111);
        chk("R5 single pulse", resume_ready, 0);
        chk("R9 flag after stop", brk_flag, expf);
    endtask

    task automatic reset_seq(input logic use_int);
        int n;
        int bad;
        if (use_int) int_rst = 1; else rst_pin = 1;
        tick(); idle();
        expf = 0;
        n = 1; bad = 0;
        chk("R10 flag cleared by reset", brk_flag, 0);
        chk("R8 reset recovery gates", gv(), 3'b011);
        while (!rst_vec_go && n < 200) begin
            tick(); n++;
            if (gv() != 3'b011) bad++;
        end
        chk("R8 vector cycle", n, 64);
        chk("R8 gates held", bad, 0);
        tick();
        chk("R8 run after vector", gv(), 3'b111);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vecs++; errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        idle(); short_rec = 0; rst = 1;
        tick(); tick(); rst = 0;
        chk("R1 reset gates", gv(), 3'b111);
        chk("R1 reset pulses", {resume_ready, rst_vec_go}, 0);
        chk("R1 reset flag", brk_flag, 0);

        // R9: break while running does not set the flag
        brk = 1; tick(); idle();
        chk("R9 brk in run", brk_flag, 0);

        go_wait(); wake_wait(0);
        go_wait(); wake_wait(1);
        // R10: software clear
        brk_flag_clr = 1; tick(); idle(); expf = 0;
        chk("R10 sw clear", brk_flag, 0);

        // R6: wake beats sleep requests
        stop_req = 1; irq = 1; tick(); idle();
        chk("R6 stop vs irq", gv(), 3'b111);
        wait_req = 1; brk = 1; tick(); idle();
        chk("R6 wait vs brk", gv(), 3'b111);
        chk("R9 brk in run with wait_req", brk_flag, 0);

        // R7: stop wins over wait
        stop_req = 1; wait_req = 1; tick(); idle();
        chk("R7 stop priority", gv(), 3'b000);
        stop_recover(0, 0);

        go_stop(1); stop_recover(1, 1);

        // R10: set wins over software clear in wait
        go_wait();
        brk = 1; brk_flag_clr = 1; tick(); idle(); expf = 1;
        chk("R10 set beats clear", brk_flag, 1);

        go_wait(); reset_seq(1);
        go_stop(0); reset_seq(0);

        for (int i = 0; i < 14; i++) begin
            int op;
            logic b;
            op = $urandom % 5;
            b  = $urandom % 2;
            case (op)
                0: begin go_wait(); wake_wait(b); end
                1: begin go_stop(1); stop_recover(1, b); end
                2: begin go_stop(($urandom % 4) == 0 ? 1'b0 : 1'b1); stop_recover(short_rec ? 1'b0 : 1'b1, b); end
                3: begin if (b) go_wait(); reset_seq($urandom % 2); end
                default: begin
                    brk_flag_clr = 1; tick(); idle(); expf = 0;
                    chk("R10 random sw clear", brk_flag, 0);
                end
            endcase
        end
        report();
    end

endmodule